// File: doc/BRIEF.md
# Compressed Temperature Triple Cache

This block takes a stream of 8-bit temperature readings and packs every three consecutive readings into a single byte. Each of the two outer readings becomes a coarse range code of six possible values. The middle reading becomes a 2-bit code that describes how it relates to its two neighbours. The packed bytes go into a circular buffer of 256 entries. The buffer is emptied through a byte-wide valid/ready output toward a terminal.

Readings can arrive at any time, and the buffer fills whatever the state of the shared bus. Draining is allowed only while the external bus-idle input is high, so terminal traffic never competes with bus transfers. When the buffer is full, completed triples are discarded and a sticky overflow flag records the loss.

Top module: `temp_triple_cache`

## Requirements
- R1: The packed byte has the first reading's range code in bits [7:5], the middle code in bits [4:3] and the third reading's range code in bits [2:0]. A range code is 0 for values up to 25, 1 for 26..29, 2 for exactly 30, 3 for 31..32, 4 for 33..35 and 5 for 36 and above. Codes 6 and 7 never appear.
- R2: The middle code is chosen in this priority order. It is 3 when the middle reading is greater than or equal to both outer readings. Otherwise it is 0 when the middle reading is less than or equal to both. Otherwise it is 1 when the middle reading differs by at most 1 from floor((first+third)/2). Otherwise it is 2.
- R3: An internal position counter (0..2) collects the readings, and a byte is written only when the third reading of a triple is accepted. A pulse on `restart` returns the counter to position 0 and discards any partial triple. A reading presented in the same cycle as `restart` is ignored.
- R4: The buffer holds 256 bytes, counting a byte presented at the output until it is accepted. `full` is high at 256 stored bytes and `empty` is high at zero.
- R5: A triple completed while `full` is high is discarded and sets `overflow`. `overflow` stays high until reset or a pulse on `overflow_clr`.
- R6: A new byte is presented only while `bus_idle` is high. Readings are still accepted and stored while `bus_idle` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold. Each accepted handshake removes exactly one byte, and bytes leave in the order they were written.
- R8: If `bus_idle` falls while a byte is presented, that byte stays presented and may still be accepted. No further byte is presented until `bus_idle` returns high.
- R9: After reset, `empty` is 1 and `full`, `overflow` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | A reading is present on `sample` |
| sample | input | 8 | Temperature reading |
| restart | input | 1 | Synchronous restart of the triple position |
| overflow_clr | input | 1 | Clears the sticky overflow flag |
| bus_idle | input | 1 | Draining is allowed while high |
| out_valid | output | 1 | `out_data` holds a packed byte |
| out_ready | input | 1 | The terminal side takes the byte |
| out_data | output | 8 | Packed triple |
| full | output | 1 | Buffer holds 256 bytes |
| empty | output | 1 | Buffer holds no bytes |
| overflow | output | 1 | Sticky flag: a completed triple was discarded |

## Verification
A wrong position counter shows up within a single triple as a byte whose fields are shifted or mixed. A missing byte after three readings shows as `empty` staying high. A wrong occupancy count shows at the 256-entry boundary as `full` rising one triple early or late, or as a drain that returns 255 or 257 bytes. A read pointer out of step with the write pointer shows at the first drained byte as codes out of order against the written pattern. Broken gating on `bus_idle` appears within two cycles as `out_valid` rising while the bus is busy.

// File: rtl/temp_triple_cache.sv
module temp_triple_cache #(
  parameter int DW    = 8,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_valid,
  input  logic [DW-1:0] sample,
  input  logic          restart,
  input  logic          overflow_clr,
  input  logic          bus_idle,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          full,
  output logic          empty,
  output logic          overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [2:0] range_code(input logic [DW-1:0] v);
    if (v < DW'(26))      return 3'd0;
    else if (v < DW'(30)) return 3'd1;
    else if (v < DW'(31)) return 3'd2;
    else if (v < DW'(33)) return 3'd3;
    else if (v < DW'(36)) return 3'd4;
    else                  return 3'd5;
  endfunction

  logic [1:0]    phase;
  logic [DW-1:0] first_q, mid_q;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  logic [DW-1:0] hi, lo;
  logic [DW:0]   avg;
  logic [1:0]    mid_code;
  logic [7:0]    packed_byte;

  always_comb begin
    hi  = (first_q > sample) ? first_q : sample;
    lo  = (first_q > sample) ? sample : first_q;
    avg = ({1'b0, first_q} + {1'b0, sample}) >> 1;
    if (mid_q >= hi)                                             mid_code = 2'b11;
    else if (mid_q <= lo)                                        mid_code = 2'b00;
    else if (({1'b0, mid_q} + 1'b1 >= avg) && ({1'b0, mid_q} <= avg + 1'b1)) mid_code = 2'b01;
    else                                                         mid_code = 2'b10;
  end

  assign packed_byte = {range_code(first_q), mid_code, range_code(sample)};

  wire take     = sample_valid && !restart;
  wire last     = take && (phase == 2'd2);
  wire wr       = last && !full;
  wire drop     = last && full;
  wire accept   = out_valid && out_ready;
  wire unfetch  = (cnt != CW'(out_valid));
  wire fetch    = bus_idle && unfetch && (!out_valid || out_ready);

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      first_q <= '0;
      mid_q   <= '0;
    end else if (restart) begin
      phase <= '0;
    end else if (sample_valid) begin
      if (phase == 2'd0) first_q <= sample;
      if (phase == 2'd1) mid_q   <= sample;
      phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
    end
  end

  always_ff @(posedge clk)
    if (wr) mem[wptr] <= packed_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      overflow  <= 1'b0;
    end else begin
      if (wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      cnt <= cnt + CW'(wr) - CW'(accept);
      if (fetch) begin
        out_data  <= mem[rptr];
        out_valid <= 1'b1;
        rptr      <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end else if (accept) begin
        out_valid <= 1'b0;
      end
      if (drop)              overflow <= 1'b1;
      else if (overflow_clr) overflow <= 1'b0;
    end
  end

  a_r1_codes_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[7:5] < 3'd6) && (out_data[2:0] < 3'd6));

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);

  a_r5_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !restart && phase == 2'd2 && full) |=> overflow);

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !overflow_clr) |=> overflow);

  a_r6_no_fetch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle && !out_valid) |=> !out_valid);

  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));

  a_r8_no_refill_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle && out_valid && out_ready) |=> !out_valid);

  a_r7_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !empty);
endmodule

// File: tb/temp_triple_cache_test.sv
module temp_triple_cache_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n, sample_valid, restart, overflow_clr, bus_idle, out_ready;
  logic [7:0] sample, out_data;
  logic out_valid, full, empty, overflow;

  temp_triple_cache uut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
    .restart(restart), .overflow_clr(overflow_clr), .bus_idle(bus_idle),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .full(full), .empty(empty), .overflow(overflow)
  );

  // {first, middle, third, expected packed byte}
  localparam logic [31:0] VEC [12] = '{
    32'h140A2805, 32'h1B321F3B, 32'h1E1F224C, 32'h24141AA1,
    32'h191E2815, 32'h21212384, 32'h2020207B, 32'h1D1B1A29,
    32'hFF0000A0, 32'h00FFFF1D, 32'h231C1588, 32'h1A1D2435
  };

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v);
    sample = v;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic push3(input logic [31:0] w);
    push(w[31:24]);
    push(w[23:16]);
    push(w[15:8]);
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 8 && !out_valid; i++) @(negedge clk);
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; sample_valid = 0; sample = 0; restart = 0;
    overflow_clr = 0; bus_idle = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("R9 empty", empty, 1);
    chk("R9 full", full, 0);
    chk("R9 overflow", overflow, 0);
    chk("R9 out_valid", out_valid, 0);

    // Vector walk: R1 bins and R2 middle codes
    bus_idle = 1;
    for (int i = 0; i < 12; i++) begin
      push3(VEC[i]);
      wait_valid();
      chk("R1 R2 valid", out_valid, 1);
      chk("R1 R2 packed", out_data, VEC[i][7:0]);
      take();
    end
    chk("R7 drained", empty, 1);

    // R3: partial triple then restart
    push(8'd40);
    push(8'd40);
    chk("R3 no write after two", empty, 1);
    restart = 1;
    sample = 8'd99; sample_valid = 1;
    @(negedge clk);
    restart = 0; sample_valid = 0;
    chk("R3 restart ignores sample", empty, 1);
    push3(VEC[0]);
    wait_valid();
    chk("R3 after restart", out_data, 8'h05);
    take();

    // R6: filling while busy, no presentation
    bus_idle = 0;
    push3(VEC[1]);
    repeat (4) @(negedge clk);
    chk("R6 no present busy", out_valid, 0);
    chk("R6 filled busy", empty, 0);
    bus_idle = 1;
    wait_valid();
    chk("R6 present idle", out_data, 8'h3B);

    // R7: stall holds
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 hold valid", out_valid, 1);
      chk("R7 hold data", out_data, 8'h3B);
    end

    // R8: idle falls while presented
    push3(VEC[2]);
    bus_idle = 0;
    repeat (2) @(negedge clk);
    chk("R8 kept valid", out_valid, 1);
    chk("R8 kept data", out_data, 8'h3B);
    take();
    chk("R8 no refill", out_valid, 0);
    chk("R8 entry kept", empty, 0);
    repeat (2) @(negedge clk);
    chk("R8 still none", out_valid, 0);
    bus_idle = 1;
    wait_valid();
    chk("R8 resumes", out_data, 8'h4C);
    take();
    chk("R7 one per accept", empty, 1);

    // R4 / R5: fill to capacity, overflow, drain
    bus_idle = 0;
    for (int i = 0; i < 256; i++) begin
      push3(VEC[i % 12]);
      if (i == 254) chk("R4 not full at 255", full, 0);
    end
    chk("R4 full at 256", full, 1);
    chk("R4 not empty", empty, 0);
    chk("R5 no overflow yet", overflow, 0);
    push3(VEC[0]);
    chk("R5 overflow set", overflow, 1);
    chk("R5 still full", full, 1);

    bus_idle = 1;
    out_ready = 1;
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (out_valid) begin
        chk("R7 order", out_data, VEC[n % 12][7:0]);
        n++;
      end
    end
    out_ready = 0;
    chk("R5 dropped not stored", n, 256);
    chk("R4 empty after drain", empty, 1);
    chk("R4 full clear", full, 0);
    chk("R5 sticky", overflow, 1);
    overflow_clr = 1;
    @(negedge clk);
    overflow_clr = 0;
    chk("R5 cleared", overflow, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule